// File: doc/BRIEF.md
# Sequential Byte Programming Controller for SPI Flash

This block sits on the host side of an SPI link to a serial flash. It writes a run of consecutive bytes using the flash's sequential-program command. A run starts with a pulse on `start`, which also captures a 24-bit start address and a mode select. The bytes then arrive over a valid/ready stream, and the last one is tagged with `in_last`.

The controller opens the run with a write-enable frame. The first program frame carries the opcode, the address and one data byte. Every later program frame is only the opcode and one data byte, because the flash advances its internal address by itself.

After each program frame the controller waits for the byte to finish programming, in one of two ways:
- **Polling mode:** it reads the status register in a single CS-low window until the busy bit clears.
- **Timed mode:** it keeps CS high for a fixed worst-case programming time.

Every run, whether it succeeds or fails, closes with a write-disable frame and then a one-cycle `done` pulse. If the device stays busy past a limit on status reads, the controller raises `error` and goes straight to write-disable.

Top module: `seqprog_ctrl`

## Requirements
- R1: After `start`, the first frame is a single byte 06h (write enable).
- R2: The first program frame is 5 bytes: opcode `PROG_OP`, address bits 23..16, address bits 15..8, address bits 7..0, then the first stream byte.
- R3: Each later stream byte is sent in its own 2-byte frame: `PROG_OP`, then the data. Bytes are sent in stream order, and `in_ready` is high only while CS is deasserted between frames.
- R4: With `poll_mode`=1, each program frame is followed by a frame that sends 05h. That frame then keeps reading status bytes while CS stays low, until a status byte has bit 0 (the last bit received) equal to 0.
- R5: With `poll_mode`=0, no status frames are sent, and CS stays high for at least `T_BP_CYC` clock cycles after each program frame.
- R6: After the byte tagged `in_last` has completed, the run ends with a single-byte frame 04h (write disable).
- R7: `done` is high for exactly one cycle: the cycle after CS returns high at the end of the write-disable frame.
- R8: If `POLL_LIMIT` status bytes in one frame all read busy, the following happens:
  - `error` is set and CS is released.
  - The write-disable frame and `done` still follow.
  - No further stream bytes are accepted.
  - `error` clears on the next `start`.
- R9: The SPI link uses mode 0: SCLK is low while CS is high, MOSI is sent most significant bit first, and every frame is a whole number of 8-clock bytes.
- R10: The value on `spi_miso` while opcode, address or data bytes are shifted out has no effect on the frames or on `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; samples `start_addr` and `poll_mode` |
| start_addr | input | 24 | Flash address of the first byte |
| poll_mode | input | 1 | 1: status polling, 0: fixed programming delay |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the run |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Stream byte taken on this cycle when valid |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle pulse at the end of a run |
| error | output | 1 | Busy-poll timeout in the current or last run |

## Verification
The hardest situation to reach is the polling timeout. It needs a device that reports busy on every one of `POLL_LIMIT` consecutive status bytes inside a single CS-low window, while more stream bytes are still waiting to be sent. The bench's flash model counts the status bytes within each frame and drives the busy bit high for a programmable number of them. Setting that count above `POLL_LIMIT` while several bytes are queued forces the abort path. A normal run follows directly after, which shows that `error` clears. The model also drives `spi_miso` high during every non-status byte, so that a stray sample would be visible.

// File: rtl/seqprog_pkg.sv
package seqprog_pkg;

    localparam logic [7:0] CMD_WR_ENABLE  = 8'h06;
    localparam logic [7:0] CMD_WR_DISABLE = 8'h04;
    localparam logic [7:0] CMD_STATUS_RD  = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_FETCH,
        ST_SEND,
        ST_POLL,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_PROG,
        FR_STAT,
        FR_WRDI
    } frame_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } stream_beat_t;

    // Number of bytes the block itself shifts out in a frame
    function automatic logic [2:0] frame_len(input frame_e kind, input logic first);
        if (kind == FR_PROG) return first ? 3'd5 : 3'd2;
        return 3'd1;
    endfunction

    // Byte at position idx of a frame
    function automatic logic [7:0] frame_byte(input frame_e kind, input logic [2:0] idx,
                                              input logic first, input logic [23:0] addr,
                                              input logic [7:0] data, input logic [7:0] prog_op);
        logic [7:0] b;
        case (kind)
            FR_WREN: b = CMD_WR_ENABLE;
            FR_WRDI: b = CMD_WR_DISABLE;
            FR_STAT: b = CMD_STATUS_RD;
            default: begin
                if (idx == 3'd0) b = prog_op;
                else if (!first) b = data;
                else begin
                    case (idx)
                        3'd1:    b = addr[23:16];
                        3'd2:    b = addr[15:8];
                        3'd3:    b = addr[7:0];
                        default: b = data;
                    endcase
                end
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/seqprog_shifter.sv
module seqprog_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic       rx_bit
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] hcnt;
    logic [2:0]    bcnt;
    logic [7:0]    sr;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt   <= '0;
            bcnt   <= '0;
            sr     <= '0;
            active <= 1'b0;
            sclk   <= 1'b0;
            done   <= 1'b0;
            rx_bit <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                active <= 1'b1;
                sr     <= tx_byte;
                hcnt   <= '0;
                bcnt   <= '0;
                sclk   <= 1'b0;
            end else if (active) begin
                if (hcnt == CW'(HALF_DIV - 1)) begin
                    hcnt <= '0;
                    if (!sclk) begin
                        sclk   <= 1'b1;
                        rx_bit <= miso;
                    end else begin
                        sclk <= 1'b0;
                        sr   <= {sr[6:0], 1'b0};
                        bcnt <= bcnt + 3'd1;
                        if (bcnt == 3'd7) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    hcnt <= hcnt + CW'(1);
                end
            end
        end
    end

    assign mosi = sr[7];
    assign busy = active;

    // R9
    go_when_idle_chk: assert property (@(posedge clk) disable iff (rst) go |-> !active);

endmodule

// File: rtl/seqprog_timer.sv
module seqprog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/seqprog_ctrl.sv
module seqprog_ctrl
    import seqprog_pkg::*;
#(
    parameter logic [7:0] PROG_OP    = 8'hAF,
    parameter int         T_BP_CYC   = 400,
    parameter int         POLL_LIMIT = 4096,
    parameter int         HALF_DIV   = 2,
    parameter int         CS_GAP     = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [23:0] start_addr,
    input  logic        poll_mode,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        in_valid,
    output logic        in_ready,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        done,
    output logic        error
);
    localparam int GAP_MAX = (T_BP_CYC > CS_GAP) ? T_BP_CYC : CS_GAP;
    localparam int TW      = $clog2(GAP_MAX + 1);
    localparam int RW      = $clog2(POLL_LIMIT + 1);

    seq_state_e   state, nxt_state;
    frame_e       kind, nxt_kind;
    stream_beat_t beat_q;
    logic [2:0]   idx;
    logic         first_f, poll_q;
    logic [23:0]  addr_q;
    logic [RW-1:0] reads;
    logic         sh_go, sh_busy, sh_done, sh_rx;
    logic [7:0]   sh_tx;
    logic         tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    seqprog_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .go(sh_go), .tx_byte(sh_tx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy), .done(sh_done), .rx_bit(sh_rx)
    );

    seqprog_timer #(.W(TW)) u_gap (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            nxt_state <= ST_IDLE;
            kind      <= FR_WREN;
            nxt_kind  <= FR_WREN;
            beat_q    <= '0;
            idx       <= '0;
            first_f   <= 1'b0;
            poll_q    <= 1'b0;
            addr_q    <= '0;
            reads     <= '0;
            sh_go     <= 1'b0;
            sh_tx     <= '0;
            tmr_load  <= 1'b0;
            tmr_val   <= '0;
            spi_cs_n  <= 1'b1;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            sh_go    <= 1'b0;
            tmr_load <= 1'b0;
            done     <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    addr_q   <= start_addr;
                    poll_q   <= poll_mode;
                    first_f  <= 1'b1;
                    error    <= 1'b0;
                    spi_cs_n <= 1'b0;
                    kind     <= FR_WREN;
                    idx      <= '0;
                    sh_go    <= 1'b1;
                    sh_tx    <= CMD_WR_ENABLE;
                    state    <= ST_SEND;
                end
                ST_GAP: if (!tmr_load && tmr_zero) begin
                    if (nxt_state == ST_SEND) begin
                        spi_cs_n <= 1'b0;
                        kind     <= nxt_kind;
                        idx      <= '0;
                        sh_go    <= 1'b1;
                        sh_tx    <= frame_byte(nxt_kind, 3'd0, first_f, addr_q, beat_q.data, PROG_OP);
                    end
                    state <= nxt_state;
                end
                ST_FETCH: if (in_valid) begin
                    beat_q   <= '{data: in_data, last: in_last};
                    spi_cs_n <= 1'b0;
                    kind     <= FR_PROG;
                    idx      <= '0;
                    sh_go    <= 1'b1;
                    sh_tx    <= PROG_OP;
                    state    <= ST_SEND;
                end
                ST_SEND: if (sh_done) begin
                    if (idx + 3'd1 < frame_len(kind, first_f)) begin
                        idx   <= idx + 3'd1;
                        sh_go <= 1'b1;
                        sh_tx <= frame_byte(kind, idx + 3'd1, first_f, addr_q, beat_q.data, PROG_OP);
                    end else begin
                        case (kind)
                            FR_WREN: begin
                                spi_cs_n  <= 1'b1;
                                tmr_load  <= 1'b1;
                                tmr_val   <= TW'(CS_GAP);
                                nxt_state <= ST_FETCH;
                                state     <= ST_GAP;
                            end
                            FR_PROG: begin
                                first_f  <= 1'b0;
                                spi_cs_n <= 1'b1;
                                tmr_load <= 1'b1;
                                state    <= ST_GAP;
                                if (poll_q) begin
                                    tmr_val   <= TW'(CS_GAP);
                                    nxt_state <= ST_SEND;
                                    nxt_kind  <= FR_STAT;
                                end else begin
                                    tmr_val   <= TW'(T_BP_CYC);
                                    nxt_state <= beat_q.last ? ST_SEND : ST_FETCH;
                                    nxt_kind  <= FR_WRDI;
                                end
                            end
                            FR_STAT: begin
                                reads <= '0;
                                sh_go <= 1'b1;
                                sh_tx <= 8'h00;
                                state <= ST_POLL;
                            end
                            default: begin
                                spi_cs_n <= 1'b1;
                                state    <= ST_FIN;
                            end
                        endcase
                    end
                end
                ST_POLL: if (sh_done) begin
                    if (!sh_rx || reads == RW'(POLL_LIMIT - 1)) begin
                        spi_cs_n  <= 1'b1;
                        tmr_load  <= 1'b1;
                        tmr_val   <= TW'(CS_GAP);
                        state     <= ST_GAP;
                        nxt_kind  <= FR_WRDI;
                        if (sh_rx) begin
                            error     <= 1'b1;
                            nxt_state <= ST_SEND;
                        end else begin
                            nxt_state <= beat_q.last ? ST_SEND : ST_FETCH;
                        end
                    end else begin
                        reads <= reads + RW'(1);
                        sh_go <= 1'b1;
                    end
                end
                ST_FIN: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign in_ready = (state == ST_FETCH);

    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) spi_cs_n |-> !spi_sclk);
    // R9
    cs_byte_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> $past(sh_done) && !sh_busy);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R7
    done_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n && $past(spi_cs_n));
    // R3
    ready_gap_chk: assert property (@(posedge clk) disable iff (rst) in_ready |-> spi_cs_n);
    // R8
    err_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> $rose(spi_cs_n));

endmodule

// File: tb/seqprog_ctrl_test.sv
module seqprog_ctrl_test;
    localparam int T_BP   = 40;
    localparam int PLIM   = 6;
    localparam logic [7:0] POP = 8'hAF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [23:0] start_addr = '0;
    logic poll_mode = 1'b0;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready, spi_cs_n, spi_sclk, spi_mosi, done, error;
    logic spi_miso = 1'b1;

    always #10 clk = ~clk;

    seqprog_ctrl #(.PROG_OP(POP), .T_BP_CYC(T_BP), .POLL_LIMIT(PLIM),
                   .HALF_DIV(2), .CS_GAP(2)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .poll_mode(poll_mode), .in_data(in_data), .in_last(in_last),
        .in_valid(in_valid), .in_ready(in_ready), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .done(done), .error(error)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // flash model / monitor state
    logic [7:0] fb [0:63][0:15];
    int flen [0:63];
    int gap_before [0:63];
    int nfr, bytes, bits, gap, busy_reads, done_cnt, done_bad, sclk_bad, bits_bad;
    logic [7:0] shreg;
    logic prev_cs, prev_sclk, prev_done, mon_clr;

    initial mon_clr = 1'b0;

    always @(negedge clk) begin
        if (rst || mon_clr) begin
            nfr = 0; bytes = 0; bits = 0; gap = 0;
            done_cnt = 0; done_bad = 0; sclk_bad = 0; bits_bad = 0;
            prev_cs = 1'b1; prev_sclk = 1'b0; prev_done = 1'b0;
        end else begin
            if (spi_cs_n && spi_sclk) sclk_bad++;
            if (done) begin
                done_cnt++;
                if (!spi_cs_n || prev_done) done_bad++;
            end
            if (!spi_cs_n && prev_cs) begin
                gap_before[nfr] = gap; gap = 0; bits = 0; bytes = 0;
            end
            if (spi_cs_n && !prev_cs) begin
                flen[nfr] = bytes;
                if (bits % 8 != 0) bits_bad++;
                if (nfr < 63) nfr++;
            end
            if (spi_cs_n) gap++;
            if (!spi_cs_n && spi_sclk && !prev_sclk) begin
                shreg = {shreg[6:0], spi_mosi};
                bits++;
                if (bits % 8 == 0) begin
                    if (bytes < 16) fb[nfr][bytes] = shreg;
                    bytes++;
                end
            end
            prev_cs = spi_cs_n; prev_sclk = spi_sclk; prev_done = done;
        end
        // status bytes: busy flag in the final bit; all other bytes drive 1 (R10)
        if (!spi_cs_n && bytes >= 1 && fb[nfr][0] == 8'h05)
            spi_miso = (bits % 8 == 7) && ((bytes - 1) < busy_reads);
        else
            spi_miso = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int i);
        return 8'(8'h5A + 8'(i * 37));
    endfunction

    int accepted;

    task automatic run(input bit poll, input int n, input int busy, input logic [23:0] a);
        @(negedge clk);
        mon_clr = 1'b1;
        busy_reads = busy;
        @(negedge clk);
        mon_clr = 1'b0;
        start = 1'b1; start_addr = a; poll_mode = poll;
        @(negedge clk);
        start = 1'b0;
        accepted = 0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = dval(i); in_last = (i == n - 1);
            while (!in_ready && done_cnt == 0) @(negedge clk);
            if (done_cnt != 0) break;
            @(negedge clk);
            accepted++;
        end
        in_valid = 1'b0;
        for (int c = 0; c < 30000 && done_cnt == 0; c++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_run(input bit poll, input int n, input int busy, input logic [23:0] a,
                             input bit tmo);
        int f = 1;
        int sent = tmo ? 1 : n;
        chk(flen[0] == 1 && fb[0][0] == 8'h06, "R1", "write-enable frame", fb[0][0], 8'h06);
        for (int i = 0; i < sent; i++) begin
            if (i == 0) begin
                chk(flen[f] == 5, "R2", "first program frame length", flen[f], 5);
                chk(fb[f][0] == POP && fb[f][1] == a[23:16] && fb[f][2] == a[15:8] &&
                    fb[f][3] == a[7:0], "R2", "opcode and address bytes",
                    {fb[f][1], fb[f][2], fb[f][3]}, a);
                chk(fb[f][4] == dval(0), "R2", "first data byte", fb[f][4], dval(0));
            end else begin
                chk(flen[f] == 2 && fb[f][0] == POP, "R3", "short frame length", flen[f], 2);
                chk(fb[f][1] == dval(i), "R3", "data order", fb[f][1], dval(i));
            end
            f++;
            if (poll) begin
                chk(fb[f][0] == 8'h05, "R4", "status opcode", fb[f][0], 8'h05);
                chk(flen[f] == 1 + (tmo ? PLIM : busy + 1), tmo ? "R8" : "R4",
                    "status frame length", flen[f], 1 + (tmo ? PLIM : busy + 1));
                f++;
            end else begin
                chk(gap_before[f] >= T_BP, "R5", "CS high after program", gap_before[f], T_BP);
            end
        end
        chk(flen[f] == 1 && fb[f][0] == 8'h04, "R6", "write-disable frame", fb[f][0], 8'h04);
        chk(nfr == f + 1, "R6", "frame count", nfr, f + 1);
        chk(done_cnt == 1 && done_bad == 0, "R7", "done pulse", done_cnt, 1);
        chk(sclk_bad == 0 && bits_bad == 0, "R9", "mode 0 whole bytes", sclk_bad + bits_bad, 0);
        chk(error == tmo, tmo ? "R8" : "R10", "error flag", error, tmo);
        chk(accepted == sent, tmo ? "R8" : "R3", "bytes accepted", accepted, sent);
    endtask

    task automatic test_reset();
        chk(spi_cs_n && !spi_sclk && !done && !error && !in_ready, "R9", "reset outputs",
            {spi_cs_n, spi_sclk, done, error, in_ready}, 5'b10000);
    endtask

    task automatic test_poll();
        run(1'b1, 3, 2, 24'h123456);
        check_run(1'b1, 3, 2, 24'h123456, 1'b0);
    endtask

    task automatic test_timed();
        run(1'b0, 3, 0, 24'hABCDEF);
        check_run(1'b0, 3, 0, 24'hABCDEF, 1'b0);
    endtask

    task automatic test_timeout();
        run(1'b1, 3, 100, 24'h00F00D);
        check_run(1'b1, 3, 100, 24'h00F00D, 1'b1);
    endtask

    task automatic test_single_after_error();
        run(1'b1, 1, 0, 24'hFFFF01);
        check_run(1'b1, 1, 0, 24'hFFFF01, 1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_poll();
        test_timed();
        test_timeout();
        test_single_after_error();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule